// File: doc/BRIEF.md
# Six-Tap Half-Sample Luma Interpolator

This block produces half-sample luma values for a small motion-search window. For a half sample that lies between two integer pixels on one axis, it weights six integer pixels taken along that axis with the symmetric kernel (1, -5, 20, 20, -5, 1). It then divides the result by 32 with rounding and clips it to the 8-bit pixel range. The diagonal centre half samples have no integer neighbour on either axis. For these, the block takes a second pass over six neighbouring intermediate half-sample sums, which are not rounded or clipped, and applies a combined divisor of 1024 with rounding.

A caller streams one set of six samples per cycle, with a valid flag and a kind code that selects horizontal, vertical or centre filtering. In the horizontal and vertical kinds the block also returns the raw weighted sum. The caller can store these sums and feed six of them back in the centre kind. This gives the full set of eight half-pel positions around an integer position for a [-1, 1] search. Each result leaves the block two cycles after it entered, tagged with its kind.

Each of the two pipeline stages holds a slot state, named SLOT_EMPTY, SLOT_EDGE or SLOT_CNTR. A valid horizontal or vertical input takes the slot to SLOT_EDGE. A valid centre input takes it to SLOT_CNTR. No input, or the reserved kind, takes it to SLOT_EMPTY. Each stage's slot is reloaded every cycle from the stage before it, so any state can move to any other state in one cycle.

Top module: `hpf_sixtap`

## Requirements
- R1: For kinds horizontal (code 0) and vertical (code 1), out_pix equals clip((t0 - 5*t1 + 20*t2 + 20*t3 - 5*t4 + t5 + 16) >> 5). Here tap k is the 16-bit field in_taps[16k+15:16k], read as an unsigned pixel.
- R2: Results below 0 come out as 0, and results above 255 come out as 255.
- R3: For the centre kind (code 2), each tap field is a signed 16-bit two's-complement intermediate. out_pix equals clip((weighted sum + 512) >> 10), where the shift is arithmetic.
- R4: out_valid rises exactly two clock cycles after a cycle with in_valid high and a kind other than 3. The block accepts one input set every cycle.
- R5: out_raw carries the unrounded weighted sum, as 16-bit two's complement, for the horizontal and vertical kinds. It is 0 for the centre kind.
- R6: out_kind carries the kind code of the input that produced the result.
- R7: An input with kind code 3 produces no output: out_valid stays low two cycles later.
- R8: In the horizontal and vertical kinds, only bits [7:0] of each tap field are used. Bits [15:8] have no effect on the result.
- R9: While out_valid is low, out_pix, out_raw and out_kind keep their previous values.
- R10: During reset and after it, until the first result, out_valid, out_pix, out_raw and out_kind are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample set is present this cycle |
| in_kind | input | 2 | 0 horizontal, 1 vertical, 2 centre, 3 reserved |
| in_taps | input | 96 | Six 16-bit taps, tap 0 in the low bits |
| out_valid | output | 1 | A result is present |
| out_kind | output | 2 | Kind code of the result |
| out_pix | output | 8 | Rounded and clipped half sample |
| out_raw | output | 16 | Unrounded weighted sum (edge kinds only) |

## Verification
A corrupted pair sum in the first stage, or a wrong bias or shift in the second stage, shows up on out_pix, and on out_raw for edge kinds, on the very result that passed through. That is two cycles after the bad input. A slot state stuck or decoded wrongly shows up as a missing or extra out_valid, or as a wrong out_kind, in that same window. A hold fault shows up on the first idle cycle after it. The sweeps exercise every 8-bit value at every tap position, and every value on both clipping edges. They also carry polluted upper bytes in the edge kinds and random full-range centre inputs, so that a misplaced bit or a wrong sign extension changes at least one result.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

    // Kind code driven by the caller with each sample set.
    typedef enum logic [1:0] {
        KIND_HORZ = 2'd0,
        KIND_VERT = 2'd1,
        KIND_CNTR = 2'd2,
        KIND_NONE = 2'd3
    } hp_kind_e;

    // Occupancy state of one pipeline slot.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_EDGE  = 2'd1,
        SLOT_CNTR  = 2'd2
    } slot_e;

    // Kernel shape and the two normalising shifts.
    localparam int NTAP       = 6;
    localparam int W_OUTER    = 1;
    localparam int W_MIDDLE   = 5;
    localparam int W_INNER    = 20;
    localparam int EDGE_SHIFT = 5;
    localparam int CNTR_SHIFT = 10;

endpackage

// File: rtl/hpf_pair_stage.sv
module hpf_pair_stage
    import hpf_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int MID_W = 16,
    parameter int ACC_W = MID_W + 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  hp_kind_e                     in_kind,
    input  logic [NTAP*MID_W-1:0]        in_taps,
    output slot_e                        slot_q,
    output hp_kind_e                     kind_q,
    output logic signed [ACC_W-1:0]      pair_outer_q,
    output logic signed [ACC_W-1:0]      pair_middle_q,
    output logic signed [ACC_W-1:0]      pair_inner_q
);

    localparam int PAD_PIX = ACC_W - PIX_W;
    localparam int PAD_MID = ACC_W - MID_W;

    slot_e                   slot_d;
    logic signed [ACC_W-1:0] ext [NTAP];
    logic signed [ACC_W-1:0] outer_d;
    logic signed [ACC_W-1:0] middle_d;
    logic signed [ACC_W-1:0] inner_d;

    // Widen each tap: zero-extend a pixel byte for edge kinds,
    // sign-extend the full intermediate word for the centre kind.
    for (genvar g = 0; g < NTAP; g++) begin : g_ext
        logic [MID_W-1:0] word;
        assign word   = in_taps[g*MID_W +: MID_W];
        assign ext[g] = (in_kind == KIND_CNTR)
                      ? {{PAD_MID{word[MID_W-1]}}, word}
                      : {{PAD_PIX{1'b0}}, word[PIX_W-1:0]};
    end

    // Fold the symmetric kernel into three pair sums.
    assign outer_d  = ext[0] + ext[NTAP-1];
    assign middle_d = ext[1] + ext[NTAP-2];
    assign inner_d  = ext[2] + ext[NTAP-3];

    // Next slot state.
    always_comb begin
        slot_d = SLOT_EMPTY;
        if (in_valid) begin
            unique case (in_kind)
                KIND_HORZ, KIND_VERT: slot_d = SLOT_EDGE;
                KIND_CNTR:            slot_d = SLOT_CNTR;
                KIND_NONE:            slot_d = SLOT_EMPTY;
            endcase
        end
    end

    // Slot state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SLOT_EMPTY;
        end else begin
            slot_q <= slot_d;
        end
    end

    // Data registers, loaded only when the slot fills.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q        <= KIND_HORZ;
            pair_outer_q  <= '0;
            pair_middle_q <= '0;
            pair_inner_q  <= '0;
        end else if (slot_d != SLOT_EMPTY) begin
            kind_q        <= in_kind;
            pair_outer_q  <= outer_d;
            pair_middle_q <= middle_d;
            pair_inner_q  <= inner_d;
        end
    end

endmodule

// File: rtl/hpf_round_stage.sv
module hpf_round_stage
    import hpf_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int MID_W = 16,
    parameter int ACC_W = MID_W + 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  slot_e                    slot_i,
    input  hp_kind_e                 kind_i,
    input  logic signed [ACC_W-1:0]  pair_outer_i,
    input  logic signed [ACC_W-1:0]  pair_middle_i,
    input  logic signed [ACC_W-1:0]  pair_inner_i,
    output logic                     out_valid,
    output logic [1:0]               out_kind,
    output logic [PIX_W-1:0]         out_pix,
    output logic [MID_W-1:0]         out_raw
);

    localparam logic signed [ACC_W-1:0] EDGE_BIAS = ACC_W'(1 << (EDGE_SHIFT - 1));
    localparam logic signed [ACC_W-1:0] CNTR_BIAS = ACC_W'(1 << (CNTR_SHIFT - 1));
    localparam logic signed [ACC_W-1:0] PIX_MAX   = ACC_W'((1 << PIX_W) - 1);

    slot_e                   state;
    logic signed [ACC_W-1:0] wsum;
    logic signed [ACC_W-1:0] rnd;
    logic [PIX_W-1:0]        pix_d;
    logic [MID_W-1:0]        raw_d;

    assign state = slot_i;

    // Weighted sum from shifts and adds: 20 = 16 + 4, 5 = 4 + 1.
    assign wsum = (pair_inner_i <<< 4) + (pair_inner_i <<< 2)
                - (pair_middle_i <<< 2) - pair_middle_i
                + pair_outer_i;

    // Rounding and normalisation chosen by slot state.
    always_comb begin
        rnd   = '0;
        raw_d = '0;
        unique case (state)
            SLOT_EDGE: begin
                rnd   = (wsum + EDGE_BIAS) >>> EDGE_SHIFT;
                raw_d = wsum[MID_W-1:0];
            end
            SLOT_CNTR: begin
                rnd   = (wsum + CNTR_BIAS) >>> CNTR_SHIFT;
                raw_d = '0;
            end
            default: begin
                rnd   = '0;
                raw_d = '0;
            end
        endcase
    end

    // Saturate to the pixel range.
    always_comb begin
        if (rnd < 0) begin
            pix_d = '0;
        end else if (rnd > PIX_MAX) begin
            pix_d = '1;
        end else begin
            pix_d = rnd[PIX_W-1:0];
        end
    end

    // Output state: valid follows occupancy.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= (state != SLOT_EMPTY);
        end
    end

    // Output data, held while the slot is empty.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_kind <= '0;
            out_pix  <= '0;
            out_raw  <= '0;
        end else if (state != SLOT_EMPTY) begin
            out_kind <= kind_i;
            out_pix  <= pix_d;
            out_raw  <= raw_d;
        end
    end

endmodule

// File: rtl/hpf_sixtap.sv
module hpf_sixtap
    import hpf_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int MID_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_kind,
    input  logic [6*MID_W-1:0]      in_taps,
    output logic                    out_valid,
    output logic [1:0]              out_kind,
    output logic [PIX_W-1:0]        out_pix,
    output logic [MID_W-1:0]        out_raw
);

    // Headroom: kernel magnitude sum is 52, below 2**6, plus a sign bit.
    localparam int ACC_W = MID_W + 7;

    hp_kind_e                kind_in;
    slot_e                   s1_slot;
    hp_kind_e                s1_kind;
    logic signed [ACC_W-1:0] s1_outer;
    logic signed [ACC_W-1:0] s1_middle;
    logic signed [ACC_W-1:0] s1_inner;

    assign kind_in = hp_kind_e'(in_kind);

    hpf_pair_stage #(
        .PIX_W (PIX_W),
        .MID_W (MID_W),
        .ACC_W (ACC_W)
    ) u_pair (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_kind       (kind_in),
        .in_taps       (in_taps),
        .slot_q        (s1_slot),
        .kind_q        (s1_kind),
        .pair_outer_q  (s1_outer),
        .pair_middle_q (s1_middle),
        .pair_inner_q  (s1_inner)
    );

    hpf_round_stage #(
        .PIX_W (PIX_W),
        .MID_W (MID_W),
        .ACC_W (ACC_W)
    ) u_round (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_i        (s1_slot),
        .kind_i        (s1_kind),
        .pair_outer_i  (s1_outer),
        .pair_middle_i (s1_middle),
        .pair_inner_i  (s1_inner),
        .out_valid     (out_valid),
        .out_kind      (out_kind),
        .out_pix       (out_pix),
        .out_raw       (out_raw)
    );

endmodule

// File: rtl/hpf_sixtap_chk.sv
module hpf_sixtap_chk #(
    parameter int PIX_W = 8,
    parameter int MID_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         in_kind,
    input logic               out_valid,
    input logic [1:0]         out_kind,
    input logic [PIX_W-1:0]   out_pix,
    input logic [MID_W-1:0]   out_raw
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    function automatic logic [PIX_W-1:0] edge_pix(input logic [MID_W-1:0] r);
        int s;
        s = (int'($signed(r)) + 16) >>> 5;
        if (s < 0) return '0;
        if (s > (1 << PIX_W) - 1) return '1;
        return PIX_W'(s);
    endfunction

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_valid == $past(in_valid && (in_kind != 2'd3), 2)));

    assert_kind_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd2) && out_valid) |-> (out_kind == $past(in_kind, 2)));

    assert_no_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_kind != 2'd3));

    assert_raw_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == 2'd2)) |-> (out_raw == '0));

    assert_edge_round_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind != 2'd2)) |-> (out_pix == edge_pix(out_raw)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd2) && !out_valid) |->
            ($stable(out_pix) && $stable(out_raw) && $stable(out_kind)));

endmodule

bind hpf_sixtap hpf_sixtap_chk #(
    .PIX_W (PIX_W),
    .MID_W (MID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_pix   (out_pix),
    .out_raw   (out_raw)
);

// File: tb/hpf_sixtap_bench.sv
module hpf_sixtap_bench;

    localparam int PIX_W = 8;
    localparam int MID_W = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [1:0]         in_kind = 2'd0;
    logic [6*MID_W-1:0] in_taps = '0;
    logic               out_valid;
    logic [1:0]         out_kind;
    logic [PIX_W-1:0]   out_pix;
    logic [MID_W-1:0]   out_raw;

    always #4 clk = ~clk;

    hpf_sixtap #(.PIX_W(PIX_W), .MID_W(MID_W)) u_hpf_sixtap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_taps(in_taps), .out_valid(out_valid), .out_kind(out_kind),
        .out_pix(out_pix), .out_raw(out_raw)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    int          cur [6];
    int unsigned rs = 32'h1234_5678;

    // Two-entry model of the expected output stream.
    bit    p_val  [2];
    int    p_kind [2];
    int    p_pix  [2];
    int    p_raw  [2];
    string p_tag  [2];
    int    h_kind = 0, h_pix = 0, h_raw = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int unsigned rnd32();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic int sx16(input int x);
        int y;
        y = x & 32'hFFFF;
        if (y >= 32768) y = y - 65536;
        return y;
    endfunction

    // One cycle: check the output due now, then drive the next input.
    task automatic step(input bit v, input logic [1:0] k, input string etag);
        int  tv [6];
        int  sum, r;
        bit  edge_k;
        @(negedge clk);
        if (p_val[1]) begin
            chk(out_valid == 1'b1, "R4", int'(out_valid), 1);
            chk(int'(out_kind) == p_kind[1], "R6", int'(out_kind), p_kind[1]);
            chk(int'(out_pix) == p_pix[1], p_tag[1], int'(out_pix), p_pix[1]);
            chk(int'(out_raw) == p_raw[1], "R5", int'(out_raw), p_raw[1]);
            h_kind = p_kind[1]; h_pix = p_pix[1]; h_raw = p_raw[1];
        end else begin
            chk(out_valid == 1'b0, p_tag[1], int'(out_valid), 0);
            chk(int'(out_pix) == h_pix, "R9", int'(out_pix), h_pix);
            chk(int'(out_raw) == h_raw, "R9", int'(out_raw), h_raw);
            chk(int'(out_kind) == h_kind, "R9", int'(out_kind), h_kind);
        end
        p_val[1] = p_val[0]; p_kind[1] = p_kind[0];
        p_pix[1] = p_pix[0]; p_raw[1] = p_raw[0]; p_tag[1] = p_tag[0];

        edge_k = (k != 2'd2);
        for (int i = 0; i < 6; i++) tv[i] = edge_k ? (cur[i] & 255) : sx16(cur[i]);
        sum = tv[0] - 5*tv[1] + 20*tv[2] + 20*tv[3] - 5*tv[4] + tv[5];
        r = edge_k ? ((sum + 16) >>> 5) : ((sum + 512) >>> 10);
        p_val[0]  = v && (k != 2'd3);
        p_kind[0] = int'(k);
        p_raw[0]  = edge_k ? (sum & 32'hFFFF) : 0;
        if (r < 0 || r > 255) p_tag[0] = "R2";
        else p_tag[0] = etag;
        p_pix[0]  = (r < 0) ? 0 : ((r > 255) ? 255 : r);
        if (!p_val[0]) p_tag[0] = (v && k == 2'd3) ? "R7" : "R4";

        in_valid = v;
        in_kind  = k;
        for (int i = 0; i < 6; i++) in_taps[i*MID_W +: MID_W] = MID_W'(cur[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            p_val[i] = 1'b0; p_kind[i] = 0; p_pix[i] = 0; p_raw[i] = 0; p_tag[i] = "R4";
        end
        for (int i = 0; i < 6; i++) cur[i] = 0;

        // R10: outputs during reset and after release.
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
        chk(out_pix == '0, "R10", int'(out_pix), 0);
        chk(out_raw == '0, "R10", int'(out_raw), 0);
        chk(out_kind == '0, "R10", int'(out_kind), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && out_pix == '0 && out_raw == '0 && out_kind == '0,
            "R10", int'(out_pix), 0);

        // R1: every byte value at every tap position, horizontal and vertical.
        for (int pos = 0; pos < 6; pos++) begin
            for (int v = 0; v < 256; v++) begin
                for (int i = 0; i < 6; i++) cur[i] = 0;
                cur[pos] = v;
                step(1'b1, (v & 1) ? 2'd1 : 2'd0, "R1");
            end
        end

        // R8: same sweep with polluted upper bytes in edge kinds.
        for (int pos = 0; pos < 6; pos++) begin
            for (int v = 0; v < 256; v++) begin
                for (int i = 0; i < 6; i++) cur[i] = int'(rnd32() & 32'hFF00);
                cur[pos] = cur[pos] | v;
                step(1'b1, (v & 2) ? 2'd1 : 2'd0, "R8");
            end
        end

        // R2: both clipping edges over every pixel value.
        for (int v = 0; v < 256; v++) begin
            cur = '{0, 0, v, v, 0, 0};
            step(1'b1, 2'd0, "R2");
            cur = '{v, v, 0, 0, v, v};
            step(1'b1, 2'd1, "R2");
        end

        // R1, R7, R9: random edge inputs with gaps and reserved kinds.
        for (int n = 0; n < 1500; n++) begin
            for (int i = 0; i < 6; i++) cur[i] = int'(rnd32() & 32'hFF);
            if (n % 7 == 3) step(1'b0, 2'd0, "R1");
            else if (n % 11 == 5) step(1'b1, 2'd3, "R7");
            else step(1'b1, (n & 1) ? 2'd1 : 2'd0, "R1");
        end

        // R3: centre kind over realistic intermediate values.
        for (int n = 0; n < 1500; n++) begin
            for (int i = 0; i < 6; i++) cur[i] = int'(rnd32() % 12751) - 2550;
            if (n % 9 == 4) step(1'b0, 2'd2, "R3");
            else step(1'b1, 2'd2, "R3");
        end

        // R3: centre kind over the full signed 16-bit range, mixed with edges.
        for (int n = 0; n < 1500; n++) begin
            for (int i = 0; i < 6; i++) cur[i] = int'(rnd32() & 32'hFFFF);
            if (n % 5 == 2) step(1'b1, 2'd0, "R8");
            else if (n % 13 == 6) step(1'b1, 2'd3, "R7");
            else step(1'b1, 2'd2, "R3");
        end

        // Centre extremes.
        cur = '{-32768, -32768, 32767, 32767, -32768, -32768};
        step(1'b1, 2'd2, "R3");
        cur = '{32767, 32767, -32768, -32768, 32767, 32767};
        step(1'b1, 2'd2, "R3");

        // Drain and confirm hold on idle cycles.
        for (int n = 0; n < 4; n++) step(1'b0, 2'd0, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule